// File: doc/BRIEF.md
# Scaled Indexed Address Generator

This unit forms the effective address of a register-indexed load or store. It adds a base register value to an index register value that has been shifted left by a two-bit scale amount, so that element sizes of 1, 2, 4 or 8 bytes can be reached directly. A flag can ask for only the low 32 bits of the index, zero-extended to the full width, to be used as the offset.

The raw sum then passes through the address canonicalisation steps of the hart, in a fixed order. First, when pointer masking is on, the bits named by a mask input are cleared. Second, when masking is off and the hart runs with 32-bit addresses, the upper bits are zeroed. Third, when a pointer base is enabled, a base pattern is ORed in. The register width is a parameter (64 by default, and it must be above 32). By default the result is registered, so it appears one cycle after the operands.

Register-file reads, the memory port and instruction decode sit outside this unit.

Top module: `idxAddrGen`

## Requirements
- R1: With zext low, the offset is the whole index shifted left by scale (0, 1, 2 or 3 bit positions), and bits shifted past bit XLEN-1 are lost.
- R2: With zext high, only index bits 31:0 form the offset. They are zero-extended to XLEN and then shifted left by scale, so index bits XLEN-1:32 have no effect on addr.
- R3: The raw address is base plus offset modulo 2^XLEN. A carry out of bit XLEN-1 is dropped.
- R4: With pmMaskEn high, every addr bit that is set in pmMask is zero, unless pmBaseEn puts it back (R6).
- R5: With pmMaskEn low and rv32Mode high, addr bits XLEN-1:32 are zeroed before the base step. With pmMaskEn high, rv32Mode has no effect on addr.
- R6: With pmBaseEn high, pmBase is ORed into the result after the masking or truncation step, so every bit set in pmBase is set in addr, including upper bits in 32-bit mode.
- R7: With OUT_REG=1 (default), addr shows the result for the operands sampled at a rising clk edge from just after that edge. With OUT_REG=0, addr is combinational.
- R8: While rstN is low, the registered addr is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| base | input | XLEN | Base register value |
| index | input | XLEN | Index register value |
| scale | input | 2 | Left shift applied to the offset |
| zext | input | 1 | Use index[31:0] zero-extended as the offset |
| pmMaskEn | input | 1 | Enable clearing of the bits set in pmMask |
| pmMask | input | XLEN | Bits to clear when masking is enabled |
| pmBaseEn | input | 1 | Enable ORing of pmBase into the address |
| pmBase | input | XLEN | Pattern ORed into the address |
| rv32Mode | input | 1 | Hart uses 32-bit addresses |
| addr | output | XLEN | Canonical effective address |

## Verification
Every result is due exactly one clock after its operands are captured. The driver therefore sets operands on the falling edge and pushes the expected address into a queue. The monitor pops one entry 2 ns after each following rising edge and compares it with addr, so no comparison ever falls on the edge itself. The reset value is sampled at the same offset while rstN is still low. The queue must be empty at the end, so a missing or extra result is also counted as a failure.

// File: rtl/idxAddrPkg.sv
package idxAddrPkg;
  localparam int SCALE_W = 2;
  localparam int LOW_W   = 32;

  typedef struct packed {
    logic useZext;
    logic clearMask;
    logic trunc32;
    logic orBase;
  } addrStrobeT;
endpackage

// File: rtl/idxAddrCtrl.sv
module idxAddrCtrl
  import idxAddrPkg::*;
(
  input  logic       zext,
  input  logic       pmMaskEn,
  input  logic       pmBaseEn,
  input  logic       rv32Mode,
  output addrStrobeT strb
);
  // Masking wins over 32-bit truncation; base OR is independent and last.
  always_comb begin
    strb.useZext   = zext;
    strb.clearMask = pmMaskEn;
    strb.trunc32   = rv32Mode && !pmMaskEn;
    strb.orBase    = pmBaseEn;
  end
endmodule

// File: rtl/idxAddrPath.sv
module idxAddrPath
  import idxAddrPkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    base,
  input  logic [XLEN-1:0]    index,
  input  logic [SCALE_W-1:0] scale,
  input  logic [XLEN-1:0]    pmMask,
  input  logic [XLEN-1:0]    pmBase,
  input  addrStrobeT         strb,
  output logic [XLEN-1:0]    addr
);
  localparam int HI_W = XLEN - LOW_W;

  logic [XLEN-1:0] offSrc;
  logic [XLEN-1:0] offShifted;
  logic [XLEN-1:0] rawSum;
  logic [XLEN-1:0] canonAddr;
  logic [XLEN-1:0] finalAddr;

  always_comb begin
    offSrc     = strb.useZext ? {{HI_W{1'b0}}, index[LOW_W-1:0]} : index;
    offShifted = offSrc << scale;
    rawSum     = base + offShifted;
    if (strb.clearMask)
      canonAddr = rawSum & ~pmMask;
    else if (strb.trunc32)
      canonAddr = {{HI_W{1'b0}}, rawSum[LOW_W-1:0]};
    else
      canonAddr = rawSum;
    finalAddr = strb.orBase ? (canonAddr | pmBase) : canonAddr;
  end

  generate
    if (OUT_REG) begin : gRegOut
      logic [XLEN-1:0] addrQ;
      always_ff @(posedge clk) begin
        if (!rstN) addrQ <= '0;
        else       addrQ <= finalAddr;
      end
      assign addr = addrQ;
    end else begin : gCombOut
      assign addr = finalAddr;
    end
  endgenerate
endmodule

// File: rtl/idxAddrGen.sv
module idxAddrGen
  import idxAddrPkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    base,
  input  logic [XLEN-1:0]    index,
  input  logic [SCALE_W-1:0] scale,
  input  logic               zext,
  input  logic               pmMaskEn,
  input  logic [XLEN-1:0]    pmMask,
  input  logic               pmBaseEn,
  input  logic [XLEN-1:0]    pmBase,
  input  logic               rv32Mode,
  output logic [XLEN-1:0]    addr
);
  addrStrobeT strb;

  idxAddrCtrl ctrl_i (
    .zext     (zext),
    .pmMaskEn (pmMaskEn),
    .pmBaseEn (pmBaseEn),
    .rv32Mode (rv32Mode),
    .strb     (strb)
  );

  idxAddrPath #(.XLEN(XLEN), .OUT_REG(OUT_REG)) path_i (
    .clk    (clk),
    .rstN   (rstN),
    .base   (base),
    .index  (index),
    .scale  (scale),
    .pmMask (pmMask),
    .pmBase (pmBase),
    .strb   (strb),
    .addr   (addr)
  );
endmodule

// File: rtl/idxAddrGenChk.sv
module idxAddrGenChk
  import idxAddrPkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [XLEN-1:0]    base,
  input logic [XLEN-1:0]    index,
  input logic [SCALE_W-1:0] scale,
  input logic               zext,
  input logic               pmMaskEn,
  input logic [XLEN-1:0]    pmMask,
  input logic               pmBaseEn,
  input logic [XLEN-1:0]    pmBase,
  input logic               rv32Mode,
  input logic [XLEN-1:0]    addr
);
  // Operands aligned with the addr they produced.
  logic            qOk;
  logic [XLEN-1:0] qBase, qIndex, qPmMask, qPmBase;
  logic [1:0]      qScale;
  logic            qZext, qMaskEn, qBaseEn, qRv32;

  generate
    if (OUT_REG) begin : gAlignReg
      always_ff @(posedge clk) begin
        if (!rstN) qOk <= 1'b0;
        else       qOk <= 1'b1;
        qBase <= base;  qIndex <= index;  qScale <= scale;  qZext <= zext;
        qMaskEn <= pmMaskEn; qPmMask <= pmMask; qBaseEn <= pmBaseEn;
        qPmBase <= pmBase;   qRv32 <= rv32Mode;
      end
    end else begin : gAlignComb
      assign qOk = 1'b1;
      assign qBase = base;  assign qIndex = index;  assign qScale = scale;
      assign qZext = zext;  assign qMaskEn = pmMaskEn; assign qPmMask = pmMask;
      assign qBaseEn = pmBaseEn; assign qPmBase = pmBase; assign qRv32 = rv32Mode;
    end
  endgenerate

  assert_mask_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (qOk && qMaskEn && !qBaseEn) |-> ((addr & qPmMask) == '0));

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (qOk && !qMaskEn && qRv32 && !qBaseEn) |-> (addr[XLEN-1:LOW_W] == '0));

  assert_base_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (qOk && qBaseEn) |-> ((addr & qPmBase) == qPmBase));

  assert_zext_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    (qOk && qZext && qScale == 2'd0 && qBase == '0 && !qMaskEn && !qBaseEn)
      |-> (addr == {{(XLEN-LOW_W){1'b0}}, qIndex[LOW_W-1:0]}));

  assert_plain_sum_R3: assert property (@(posedge clk) disable iff (!rstN)
    (qOk && !qZext && qScale == 2'd0 && !qMaskEn && !qRv32 && !qBaseEn)
      |-> (addr == qBase + qIndex));

  generate
    if (OUT_REG) begin : gRstChk
      assert_reset_zero_R8: assert property (@(posedge clk)
        !rstN |=> (addr == '0));
    end
  endgenerate
endmodule

bind idxAddrGen idxAddrGenChk #(.XLEN(XLEN), .OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rstN(rstN), .base(base), .index(index), .scale(scale),
  .zext(zext), .pmMaskEn(pmMaskEn), .pmMask(pmMask), .pmBaseEn(pmBaseEn),
  .pmBase(pmBase), .rv32Mode(rv32Mode), .addr(addr)
);

// File: tb/idxAddrGen_tb_top.sv
module idxAddrGen_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [XLEN-1:0] base = '0, index = '0, pmMask = '0, pmBase = '0;
  logic [1:0]      scale = '0;
  logic            zext = 1'b0, pmMaskEn = 1'b0, pmBaseEn = 1'b0, rv32Mode = 1'b0;
  logic [XLEN-1:0] addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [XLEN-1:0] exp;
    string           tag;
  } expItemT;
  expItemT sbQ[$];

  always #5 clk = ~clk;

  idxAddrGen #(.XLEN(XLEN), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .base(base), .index(index), .scale(scale),
    .zext(zext), .pmMaskEn(pmMaskEn), .pmMask(pmMask), .pmBaseEn(pmBaseEn),
    .pmBase(pmBase), .rv32Mode(rv32Mode), .addr(addr)
  );

  // Expected value from the requirement text (R1..R6).
  function automatic logic [XLEN-1:0] model(
    logic [XLEN-1:0] b, logic [XLEN-1:0] ix, logic [1:0] sc, logic zx,
    logic mEn, logic [XLEN-1:0] m, logic bEn, logic [XLEN-1:0] pb, logic r32);
    logic [XLEN-1:0] off, a;
    off = zx ? (ix & 64'h0000_0000_FFFF_FFFF) : ix;
    for (int s = 0; s < int'(sc); s++) off = off * 2;
    a = b + off;
    if (mEn)      a = a & ~m;
    else if (r32) a = a & 64'h0000_0000_FFFF_FFFF;
    if (bEn)      a = a | pb;
    return a;
  endfunction

  task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic [XLEN-1:0] b, logic [XLEN-1:0] ix,
                       logic [1:0] sc, logic zx, logic mEn, logic [XLEN-1:0] m,
                       logic bEn, logic [XLEN-1:0] pb, logic r32);
    expItemT it;
    @(negedge clk);
    base = b; index = ix; scale = sc; zext = zx; pmMaskEn = mEn;
    pmMask = m; pmBaseEn = bEn; pmBase = pb; rv32Mode = r32;
    it.exp = model(b, ix, sc, zx, mEn, m, bEn, pb, r32);
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: result due one clock after capture (R7).
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbQ.size() > 0) begin
        expItemT it;
        it = sbQ.pop_front();
        check(it.tag, addr, it.exp);
      end
    end
  end

  function automatic logic [XLEN-1:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    // R8: reset holds addr at zero even with live operands.
    base = 64'hDEAD_BEEF_0000_1234; index = 64'h10;
    repeat (3) @(posedge clk);
    #2 check("R8 reset", addr, '0);
    @(negedge clk) rstN = 1'b1;

    // R1: full index shifted by each scale, with bits lost off the top.
    drive("R1 scale0", 64'h1000, 64'h8000_0000_0000_0003, 2'd0, 0, 0, '0, 0, '0, 0);
    drive("R1 scale3", 64'h0, 64'hF000_0000_0000_0001, 2'd3, 0, 0, '0, 0, '0, 0);
    drive("R1 scale2", 64'h100, 64'h0000_0001_0000_0004, 2'd2, 0, 0, '0, 0, '0, 0);
    // R2: upper index bits ignored under zext.
    drive("R2 zext upper ignored", 64'h0, 64'hFFFF_FFFF_8000_0001, 2'd1, 1, 0, '0, 0, '0, 0);
    drive("R2 zext scale3", 64'h5, 64'h1234_5678_FFFF_FFFF, 2'd3, 1, 0, '0, 0, '0, 0);
    // R3: carry out of the top bit dropped.
    drive("R3 wrap", 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 2'd0, 0, 0, '0, 0, '0, 0);
    // R4: mask bits cleared.
    drive("R4 mask", 64'hFF00_0000_0000_1000, 64'h1, 2'd0, 0, 1, 64'hFF00_0000_0000_0001, 0, '0, 0);
    // R5: rv32 truncation, and no effect while masking.
    drive("R5 trunc", 64'h0000_0001_FFFF_FFFF, 64'h2, 2'd0, 0, 0, '0, 0, '0, 1);
    drive("R5 mask beats rv32", 64'hABCD_0000_1234_0000, 64'h0, 2'd0, 0, 1, 64'h0F, 0, '0, 1);
    // R6: base OR after truncation and after masking.
    drive("R6 or after trunc", 64'h0000_0007_0000_0010, 64'h0, 2'd0, 0, 0, '0, 1, 64'h8000_0000_0000_0000, 1);
    drive("R6 or after mask", 64'h0, 64'h0, 2'd0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 64'h0000_0000_0000_00F0, 0);
    // R7: back-to-back operands each produce their own result one cycle later.
    drive("R7 back2back a", 64'h1, 64'h1, 2'd0, 0, 0, '0, 0, '0, 0);
    drive("R7 back2back b", 64'h2, 64'h2, 2'd1, 0, 0, '0, 0, '0, 0);

    // R1..R6: every combination of scale, zext, mask, rv32 and base enable.
    for (int mode = 0; mode < 64; mode++) begin
      for (int rep = 0; rep < 4; rep++) begin
        drive("R1-6 sweep r1_r6", rnd64(), rnd64(), mode[1:0], mode[2], mode[3],
              rnd64(), mode[4], rnd64(), mode[5]);
      end
    end

    repeat (3) @(posedge clk);
    #3;
    checks++;
    if (sbQ.size() != 0) begin
      fails++;
      $display("FAIL R7 queue drain: actual %0d expected 0", sbQ.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule